// File: doc/BRIEF.md
# Acquisition packet storage router

This block sits between a teletext-style acquisition front end and the page memory. For every decoded packet the front end signals a packet start, giving the packet kind, the packet number, the designation code and the index of the selected page the packet belongs to. It then sends the payload bytes one at a time, each with a biphase error flag. The router decides whether each byte is stored at all. When it is, the router turns the byte into one memory write carrying a chapter, row and column address.

Placement follows two mode bits. The ghost-row bit chooses between a four-page layout and a two-page layout. The two-page layout keeps extension packets and broadcast service data. The VPS enable bit gates the storage of VPS bytes. Payloads are written exactly as received, apart from the error flag that is attached to VPS bytes. All decoding of the content is left to software. Both mode bits are captured when a packet starts and stay fixed until the next packet starts.

Top module: `pkt_store_router`

## Requirements
- R1: While reset is asserted, and until the first accepted byte, `wr_en_o` is 0 and `wr_addr_o` and `wr_data_o` are 0.
- R2: Each accepted byte raises `wr_en_o` for one cycle, one clock after the byte is presented. The address is laid out as chapter in [13:11], row in [10:6] and column in [5:0]. The column is 0 for the first byte of a packet and increases by 1 for each byte presented after it.
- R3: With the ghost-row bit at 0, packets of kind 0 (page row) with packet number 0..23 from page slot s are stored in chapter s, in the row equal to the packet number.
- R4: With the ghost-row bit at 0, page-row packets numbered 24..28 and all packets of kind 1 (service data) are dropped.
- R5: With the ghost-row bit at 1, page-row packets 0..23 from slots 0 and 1 go to chapters 0 and 1. Packets from slots 2 and 3 are dropped.
- R6: With the ghost-row bit at 1, page-row packets 24..28 from slot 0 or 1 go to chapter 4 or 5 respectively, in row (packet number - 24).
- R7: With the ghost-row bit at 1, a kind-1 packet whose designation code is 2 or 3 is stored unmodified in chapter 5, row 23. Any other designation code causes the packet to be dropped.
- R8: With VPS enable at 1, a kind-2 packet (VPS) is stored in chapter 5, row 25, and `wr_data_o[8]` carries that byte's biphase error flag. For every other stored byte, `wr_data_o[8]` is 0.
- R9: With VPS enable at 0, kind-2 packets produce no write.
- R10: The ghost-row bit and VPS enable are sampled only in the packet-start cycle. Changing them in the middle of a packet has no effect on that packet.
- R11: Bytes that would fall at column 40 or beyond are dropped.
- R12: A byte presented in the same cycle as a packet start is ignored. Packets of kind 3 and page rows numbered 29..31 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ghost_mode_i | input | 1 | 1 = two-page layout that keeps ghost rows, 0 = four-page layout |
| vps_en_i | input | 1 | Enables storage of VPS data |
| pkt_start_i | input | 1 | Marks the start of a packet; qualifies the packet fields |
| pkt_kind_i | input | 2 | 0 page row, 1 service data, 2 VPS, 3 other |
| pkt_num_i | input | 5 | Packet number |
| pkt_desig_i | input | 4 | Designation code |
| page_slot_i | input | 2 | Index of the selected page the packet belongs to |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_i | input | 8 | Payload byte |
| biphase_err_i | input | 1 | Biphase error flag for the byte |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 14 | Chapter, row and column of the write |
| wr_data_o | output | 9 | Stored byte in [7:0], VPS error flag in [8] |

## Verification
Corrupt placement context shows up on the very next write strobe, one cycle after the byte, as a wrong chapter or row. A column counter that drifts shows up as a wrong column on the next byte of the same packet, or as a missing or extra strobe at the 40-column edge. A mode bit latched at the wrong moment changes the placement of the first byte after a mid-packet toggle. A reference model compared every cycle therefore catches each of these errors within one clock of the byte that exposes it.

// File: rtl/pkt_store_pkg.sv
package pkt_store_pkg;
  localparam int CHAP_W = 3;
  localparam int ROW_W  = 5;
  localparam int COL_W  = 6;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 2;
  localparam int DESIG_W = 4;
  localparam int ADDR_W = CHAP_W + ROW_W + COL_W;

  localparam int DISP_ROWS   = 24;
  localparam int GHOST_FIRST = 24;
  localparam int GHOST_LAST  = 28;
  localparam int GHOST_CHAP  = 4;
  localparam int SVC_CHAP    = 5;
  localparam int SVC_ROW     = 23;
  localparam int VPS_ROW     = 25;

  typedef enum logic [1:0] {
    PK_ROW  = 2'd0,
    PK_SVC  = 2'd1,
    PK_VPS  = 2'd2,
    PK_NONE = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    logic              keep;
    logic              tag_err;
    logic [CHAP_W-1:0] chap;
    logic [ROW_W-1:0]  row;
  } place_t;
endpackage

// File: rtl/pkt_place_decode.sv
module pkt_place_decode
  import pkt_store_pkg::*;
(
  input  logic               ghost_mode_i,
  input  logic               vps_en_i,
  input  pkt_kind_e          kind_i,
  input  logic [ROW_W-1:0]   num_i,
  input  logic [DESIG_W-1:0] desig_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output place_t             place_o
);
  logic is_disp, is_ghost, low_slot, fmt2;

  assign is_disp  = num_i < ROW_W'(DISP_ROWS);
  assign is_ghost = (num_i >= ROW_W'(GHOST_FIRST)) && (num_i <= ROW_W'(GHOST_LAST));
  assign low_slot = (slot_i >> 1) == '0;
  assign fmt2     = desig_i[DESIG_W-1:1] == {{(DESIG_W-2){1'b0}}, 1'b1};

  always_comb begin
    place_o = '0;
    unique case (kind_i)
      PK_ROW: begin
        if (is_disp && !ghost_mode_i) begin
          place_o.keep = 1'b1;
          place_o.chap = CHAP_W'(slot_i);
          place_o.row  = num_i;
        end else if (is_disp && low_slot) begin
          place_o.keep = 1'b1;
          place_o.chap = CHAP_W'(slot_i[0]);
          place_o.row  = num_i;
        end else if (is_ghost && ghost_mode_i && low_slot) begin
          place_o.keep = 1'b1;
          place_o.chap = CHAP_W'(GHOST_CHAP) + CHAP_W'(slot_i[0]);
          place_o.row  = num_i - ROW_W'(GHOST_FIRST);
        end
      end
      PK_SVC: begin
        if (ghost_mode_i && fmt2) begin
          place_o.keep = 1'b1;
          place_o.chap = CHAP_W'(SVC_CHAP);
          place_o.row  = ROW_W'(SVC_ROW);
        end
      end
      PK_VPS: begin
        if (vps_en_i) begin
          place_o.keep    = 1'b1;
          place_o.tag_err = 1'b1;
          place_o.chap    = CHAP_W'(SVC_CHAP);
          place_o.row     = ROW_W'(VPS_ROW);
        end
      end
      default: place_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_ctx.sv
module pkt_ctx
  import pkt_store_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ghost_mode_i,
  input  logic             byte_valid_i,
  input  place_t           place_i,
  output place_t           place_o,
  output logic [COL_W:0]   col_o
);
  localparam logic [COL_W:0] COL_END = (COL_W+1)'(NUM_COLS);

  place_t          place_q;
  logic [COL_W:0]  col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      place_q <= '0;
      col_q   <= '0;
    end else if (start_i) begin
      place_q <= place_i;
      col_q   <= '0;
    end else if (byte_valid_i && col_q < COL_END) begin
      col_q <= col_q + 1'b1;
    end
  end

  assign place_o = place_q;
  assign col_o   = col_q;

  // context only changes at packet boundaries
  assert_ctx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(place_q));

  assert_col_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !start_i && col_q < COL_END) |=> (col_q == $past(col_q) + 1'b1));

  assert_four_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ghost_mode_i) |=> (!place_q.keep || place_q.tag_err ||
                                     place_q.chap < CHAP_W'(GHOST_CHAP)));
endmodule

// File: rtl/pkt_store_router.sv
module pkt_store_router
  import pkt_store_pkg::*;
#(
  parameter int NUM_COLS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ghost_mode_i,
  input  logic              vps_en_i,
  input  logic              pkt_start_i,
  input  logic [1:0]        pkt_kind_i,
  input  logic [4:0]        pkt_num_i,
  input  logic [3:0]        pkt_desig_i,
  input  logic [1:0]        page_slot_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              biphase_err_i,
  output logic              wr_en_o,
  output logic [13:0]       wr_addr_o,
  output logic [8:0]        wr_data_o
);
  localparam logic [COL_W:0] COL_END = (COL_W+1)'(NUM_COLS);

  place_t         place_new, place_cur;
  logic [COL_W:0] col_cur;
  logic           accept;

  pkt_place_decode i_decode (
    .ghost_mode_i (ghost_mode_i),
    .vps_en_i     (vps_en_i),
    .kind_i       (pkt_kind_e'(pkt_kind_i)),
    .num_i        (pkt_num_i),
    .desig_i      (pkt_desig_i),
    .slot_i       (page_slot_i),
    .place_o      (place_new)
  );

  pkt_ctx #(.NUM_COLS(NUM_COLS)) i_ctx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (pkt_start_i),
    .ghost_mode_i (ghost_mode_i),
    .byte_valid_i (byte_valid_i),
    .place_i      (place_new),
    .place_o      (place_cur),
    .col_o        (col_cur)
  );

  // a byte in the start cycle belongs to no packet
  assign accept = byte_valid_i && !pkt_start_i && place_cur.keep && (col_cur < COL_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= accept;
      if (accept) begin
        wr_addr_o <= {place_cur.chap, place_cur.row, col_cur[COL_W-1:0]};
        wr_data_o <= {place_cur.tag_err & biphase_err_i, byte_i};
      end
    end
  end

  assert_col_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[COL_W-1:0] < COL_W'(NUM_COLS)));

  assert_err_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[DATA_W]) |->
      (wr_addr_o[ADDR_W-1 -: CHAP_W] == CHAP_W'(SVC_CHAP) &&
       wr_addr_o[COL_W +: ROW_W] == ROW_W'(VPS_ROW)));

  assert_strobe_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> ($past(byte_valid_i) && !$past(pkt_start_i)));
endmodule

// File: tb/test_pkt_store_router.sv
module test_pkt_store_router;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ghost_mode_i = 1'b0, vps_en_i = 1'b0, pkt_start_i = 1'b0;
  logic [1:0] pkt_kind_i = '0;
  logic [4:0] pkt_num_i = '0;
  logic [3:0] pkt_desig_i = '0;
  logic [1:0] page_slot_i = '0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic biphase_err_i = 1'b0;
  logic wr_en_o;
  logic [13:0] wr_addr_o;
  logic [8:0] wr_data_o;

  always #5 clk_i = ~clk_i;

  pkt_store_router i_pkt_store_router (.*);

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit exp_en = 0;
  int exp_addr = 0, exp_data = 0;
  int m_keep = 0, m_tag = 0, m_chap = 0, m_row = 0, m_col = 0;

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, expv);
    end
  endtask

  task automatic cycle();
    @(negedge clk_i);
    chk(wr_en_o == exp_en, "wr_en", int'(wr_en_o), int'(exp_en));
    if (exp_en) begin
      chk(int'(wr_addr_o) == exp_addr, "addr", int'(wr_addr_o), exp_addr);
      chk(int'(wr_data_o) == exp_data, "data", int'(wr_data_o), exp_data);
    end
    exp_en = 0;
  endtask

  // behavioural placement model
  task automatic start(int kind, int num, int desig, int slot, bit with_byte = 0);
    bit g = ghost_mode_i, v = vps_en_i;
    m_keep = 0; m_tag = 0; m_chap = 0; m_row = 0; m_col = 0;
    if (kind == 0 && num <= 23) begin
      if (!g) begin m_keep = 1; m_chap = slot; m_row = num; end
      else if (slot < 2) begin m_keep = 1; m_chap = slot; m_row = num; end
    end else if (kind == 0 && num >= 24 && num <= 28) begin
      if (g && slot < 2) begin m_keep = 1; m_chap = 4 + slot; m_row = num - 24; end
    end else if (kind == 1) begin
      if (g && (desig == 2 || desig == 3)) begin m_keep = 1; m_chap = 5; m_row = 23; end
    end else if (kind == 2) begin
      if (v) begin m_keep = 1; m_tag = 1; m_chap = 5; m_row = 25; end
    end
    pkt_start_i = 1; pkt_kind_i = 2'(kind); pkt_num_i = 5'(num);
    pkt_desig_i = 4'(desig); page_slot_i = 2'(slot);
    byte_valid_i = with_byte; byte_i = 8'hEE;
    cycle();
    pkt_start_i = 0; byte_valid_i = 0;
  endtask

  task automatic send(int b, bit err);
    byte_valid_i = 1; byte_i = 8'(b); biphase_err_i = err;
    if (m_keep != 0 && m_col < 40) begin
      exp_en = 1;
      exp_addr = m_chap * 2048 + m_row * 64 + m_col;
      exp_data = ((m_tag != 0 && err) ? 256 : 0) + b;
    end
    if (m_col < 40) m_col++;
    cycle();
    byte_valid_i = 0; biphase_err_i = 0;
  endtask

  task automatic burst(int n, int seed);
    for (int i = 0; i < n; i++) send((seed + i * 7) & 8'hFF, i[0]);
  endtask

  bit done = 0;
  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) cycle();
    chk(wr_addr_o == 0 && wr_data_o == 0, "reset addr/data", int'(wr_addr_o), 0);
    rst_ni = 1;
    cycle();

    cur_req = "R3"; ghost_mode_i = 0;
    start(0, 5, 0, 2); burst(3, 8'h41);
    start(0, 23, 0, 3); burst(2, 8'h10);
    cur_req = "R2"; start(0, 0, 0, 0); burst(4, 8'h61);
    cur_req = "R4"; start(0, 24, 0, 1); burst(2, 8'h30);
    start(1, 23, 2, 0); burst(2, 8'h31);

    cur_req = "R5"; ghost_mode_i = 1;
    start(0, 3, 0, 1); burst(3, 8'h52);
    start(0, 3, 0, 3); burst(2, 8'h53);
    cur_req = "R6"; start(0, 26, 0, 0); burst(2, 8'h60);
    start(0, 28, 0, 1); burst(2, 8'h62);
    start(0, 27, 0, 2); burst(2, 8'h63);
    cur_req = "R7"; start(1, 23, 2, 0); burst(3, 8'h70);
    start(1, 23, 3, 0); burst(1, 8'h71);
    start(1, 23, 0, 0); burst(2, 8'h72);

    cur_req = "R8"; vps_en_i = 1;
    start(2, 0, 0, 0); burst(4, 8'h80);
    cur_req = "R9"; vps_en_i = 0;
    start(2, 0, 0, 0); burst(3, 8'h90);

    cur_req = "R10"; ghost_mode_i = 0; vps_en_i = 1;
    start(0, 7, 0, 3); send(8'hA0, 0);
    ghost_mode_i = 1; send(8'hA1, 0); send(8'hA2, 0);
    start(2, 0, 0, 0); send(8'hA3, 1);
    vps_en_i = 0; send(8'hA4, 1);

    cur_req = "R11"; ghost_mode_i = 1;
    start(0, 9, 0, 0); burst(43, 8'h05);

    cur_req = "R12";
    start(0, 4, 0, 1, 1); burst(2, 8'hC0);
    start(0, 30, 0, 0); burst(2, 8'hC1);
    start(3, 1, 0, 0); burst(2, 8'hC2);
    repeat (2) cycle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule